// File: doc/BRIEF.md
# Eight-Channel SAR Converter Serial Front End

This block is the digital serial port and conversion sequencer for an eight-input, 12-bit successive-approximation converter. A host drives an active-low chip select, a serial clock and a serial data line into it. The block samples these three inputs with the local system clock and works out the serial clock edges from them. It divides the time while chip select is low into 16-clock conversions. Each conversion has a track phase followed by a convert phase. The block returns each result on a serial output that has its own output-enable signal.

A behavioural converter model sits beside the block. It follows the channel-select output and offers a parallel 12-bit result, and the block latches that result when the track phase ends. The host sends the channel address for the next conversion during the current one, so each address takes effect one conversion later. After reset, the first conversion uses the reset channel. Chip select may stay low over many conversions to run them back to back. Between conversions, and whenever chip select is high, the block reports power-down.

All edge positions below count serial-clock edges after the inputs have passed through the synchronizer. Outputs follow the pins within SYNC_STAGES+1 system clocks.

Top module: `sar_serial_fe`

## Requirements
- R1: `dout_oe` is high exactly while the synchronized `cs_n` is low. While `dout_oe` is low, `dout` is 0, `track` is 0 and `pwr_dn` is 1.
- R2: Serial-clock edges and `din` activity while `cs_n` is high have no effect. `chan_sel` does not change, and the next frame behaves as if that activity had not happened.
- R3: After falling edges 1 to 4 of a conversion, `dout` is 0. After falling edge 4+j (j = 1..12), `dout` carries result bit 12-j, so the most significant bit comes first.
- R4: The result sent in a conversion is the `conv_data` value present at that conversion's 4th falling edge.
- R5: `din` is shifted into an 8-bit control word on rising edges 1 to 8 of each conversion, with the first bit landing in bit 7. Bits 5:3 (bit 5 most significant, sent on rising edges 3, 4 and 5) form the channel address. Bits 7, 6, 2, 1 and 0 have no effect.
- R6: The captured address drives `chan_sel` (binary 0..7) from the 16th rising edge onward. So a conversion's result comes from the channel addressed in the previous conversion. After reset, `chan_sel` is 0.
- R7: `track` is high after falling edges 1 to 3 of a conversion and low after falling edges 4 to 16.
- R8: If `cs_n` falls while `sclk` is low, that chip-select edge counts as falling edge 1 and `track` rises at once. If `cs_n` falls while `sclk` is high, `track` and `pwr_dn` both stay low until the first `sclk` falling edge.
- R9: With `cs_n` held low, the first falling edge after the 16th rising edge starts a new conversion. That conversion has a new track phase and four new leading zeros.
- R10: `pwr_dn` is high while `cs_n` is high. It is also high from the 16th falling edge of a conversion until falling edge 1 of the next one. At all other times it is low.
- R11: If `cs_n` rises before the 16th rising edge, the partial conversion is dropped. `chan_sel` keeps its value and the following frame is sequenced from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| din | input | 1 | Host serial data, carries the control word |
| conv_data | input | 12 | Parallel result from the converter model |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Output enable for the serial data pin driver |
| chan_sel | output | 3 | Input channel selected for the converter |
| track | output | 1 | High during the track phase |
| pwr_dn | output | 1 | High while the converter may power down |

## Verification
The bench compares each 16-bit serial word with the value held for the previous conversion's channel. A design that applied the address to the conversion in progress would return the wrong channel's data. The bench starts frames with the serial clock both low and high at chip-select fall. A design that did not treat a low-clock start as the first falling edge would shift the whole word by one bit and lose the track phase. Back-to-back conversions, frames cut off partway, and clock activity while deselected are mixed with random control words. A design that committed the address early, failed to restart counting at the 17th falling edge, or counted edges while deselected would select the wrong channel.

// File: rtl/sar_fe_pkg.sv
package sar_fe_pkg;

    // Conversion phase seen by the outputs.
    typedef enum logic [2:0] {
        PH_OFF   = 3'd0,  // chip select high
        PH_WAIT  = 3'd1,  // selected, first falling edge not seen yet
        PH_TRACK = 3'd2,  // acquiring input
        PH_CONV  = 3'd3,  // converting / shifting result
        PH_GAP   = 3'd4   // between last falling edge and next conversion
    } phase_e;

endpackage

// File: rtl/sar_fe_sync.sv
module sar_fe_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/sar_fe_seq.sv
module sar_fe_seq
    import sar_fe_pkg::*;
#(
    parameter int CONV_CLKS  = 16,
    parameter int TRACK_CLKS = 3,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             sclk_s,
    output logic             active_o,
    output logic             fall_ev_o,
    output logic [CNT_W-1:0] fall_idx_o,
    output logic             rise_ev_o,
    output logic [CNT_W-1:0] rise_idx_o,
    output phase_e           phase_o
);

    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(CONV_CLKS);
    localparam logic [CNT_W-1:0] TRACK_C = CNT_W'(TRACK_CLKS);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        logic             cs;
        logic             sclk;
        logic [CNT_W-1:0] fcnt;
        logic [CNT_W-1:0] rcnt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             cs_fall;
    logic             both_low;
    logic             real_fall;
    logic             real_rise;
    logic             virt_fall;
    logic             fall_ev;
    logic [CNT_W-1:0] fall_idx;
    logic [CNT_W-1:0] rise_idx;

    always_comb begin
        cs_fall   = seq_q.cs & ~cs_s;
        both_low  = ~seq_q.cs & ~cs_s;
        real_fall = both_low & seq_q.sclk & ~sclk_s;
        real_rise = both_low & ~seq_q.sclk & sclk_s;
        // A select edge with the clock already low stands in for edge 1.
        virt_fall = cs_fall & ~sclk_s;
        fall_ev   = real_fall | virt_fall;
        fall_idx  = (seq_q.fcnt == LAST_C) ? ONE_C : seq_q.fcnt + ONE_C;
        rise_idx  = seq_q.rcnt + ONE_C;

        seq_d      = seq_q;
        seq_d.cs   = cs_s;
        seq_d.sclk = sclk_s;
        if (cs_s) begin
            seq_d.fcnt = '0;
            seq_d.rcnt = '0;
        end else begin
            if (fall_ev) begin
                seq_d.fcnt = fall_idx;
            end
            if (real_rise) begin
                seq_d.rcnt = (rise_idx == LAST_C) ? '0 : rise_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{cs: 1'b1, sclk: 1'b0, fcnt: '0, rcnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        if (seq_q.cs) begin
            phase_o = PH_OFF;
        end else if (seq_q.fcnt == '0) begin
            phase_o = PH_WAIT;
        end else if (seq_q.fcnt <= TRACK_C) begin
            phase_o = PH_TRACK;
        end else if (seq_q.fcnt < LAST_C) begin
            phase_o = PH_CONV;
        end else begin
            phase_o = PH_GAP;
        end
    end

    assign active_o   = ~seq_q.cs;
    assign fall_ev_o  = fall_ev;
    assign fall_idx_o = fall_idx;
    assign rise_ev_o  = real_rise;
    assign rise_idx_o = rise_idx;

endmodule

// File: rtl/sar_fe_datapath.sv
module sar_fe_datapath #(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 4,
    parameter int LOAD_EDGE  = 4,
    parameter int CTRL_W     = 8,
    parameter int ADDR_W     = 3,
    parameter int ADDR_LSB   = 3,
    parameter int CONV_CLKS  = 16,
    parameter int CNT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              din_s,
    input  logic              fall_ev,
    input  logic [CNT_W-1:0]  fall_idx,
    input  logic              rise_ev,
    input  logic [CNT_W-1:0]  rise_idx,
    input  logic [DATA_W-1:0] conv_data,
    output logic              dout_o,
    output logic [ADDR_W-1:0] chan_o
);

    localparam logic [CNT_W-1:0] LZ_C   = CNT_W'(LEAD_ZEROS);
    localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(LOAD_EDGE);
    localparam logic [CNT_W-1:0] CTRL_C = CNT_W'(CTRL_W);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CONV_CLKS);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              dout;
        logic [CTRL_W-1:0] ctrl;
        logic [ADDR_W-1:0] chan;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (cs_s) begin
            // Deselected: drop any partial conversion, keep the channel.
            dp_d.sh   = '0;
            dp_d.dout = 1'b0;
            dp_d.ctrl = '0;
        end else begin
            if (fall_ev) begin
                if (fall_idx <= LZ_C) begin
                    dp_d.dout = 1'b0;
                end else begin
                    dp_d.dout = dp_q.sh[DATA_W-1];
                    dp_d.sh   = {dp_q.sh[DATA_W-2:0], 1'b0};
                end
                if (fall_idx == LOAD_C) begin
                    dp_d.sh = conv_data;
                end
            end
            if (rise_ev) begin
                if (rise_idx == ONE_C) begin
                    dp_d.ctrl = {{(CTRL_W-1){1'b0}}, din_s};
                end else if (rise_idx <= CTRL_C) begin
                    dp_d.ctrl = {dp_q.ctrl[CTRL_W-2:0], din_s};
                end
                if (rise_idx == LAST_C) begin
                    dp_d.chan = dp_q.ctrl[ADDR_LSB +: ADDR_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign dout_o = dp_q.dout;
    assign chan_o = dp_q.chan;

endmodule

// File: rtl/sar_serial_fe.sv
module sar_serial_fe
    import sar_fe_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int LEAD_ZEROS  = 4,
    parameter int TRACK_CLKS  = 3,
    parameter int CTRL_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int ADDR_LSB    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [DATA_W-1:0] conv_data,
    output logic              dout,
    output logic              dout_oe,
    output logic [ADDR_W-1:0] chan_sel,
    output logic              track,
    output logic              pwr_dn
);

    localparam int CONV_CLKS = DATA_W + LEAD_ZEROS;
    localparam int CNT_W     = $clog2(CONV_CLKS + 1);
    localparam int LOAD_EDGE = TRACK_CLKS + 1;

    logic [2:0]       raw_w;
    logic [2:0]       sync_w;
    logic             cs_s;
    logic             sclk_s;
    logic             din_s;
    logic             active;
    logic             fall_ev;
    logic [CNT_W-1:0] fall_idx;
    logic             rise_ev;
    logic [CNT_W-1:0] rise_idx;
    phase_e           phase;

    assign raw_w  = {din, sclk, cs_n};
    assign cs_s   = sync_w[0];
    assign sclk_s = sync_w[1];
    assign din_s  = sync_w[2];

    sar_fe_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_w),
        .sync_o  (sync_w)
    );

    sar_fe_seq #(
        .CONV_CLKS  (CONV_CLKS),
        .TRACK_CLKS (TRACK_CLKS),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .sclk_s     (sclk_s),
        .active_o   (active),
        .fall_ev_o  (fall_ev),
        .fall_idx_o (fall_idx),
        .rise_ev_o  (rise_ev),
        .rise_idx_o (rise_idx),
        .phase_o    (phase)
    );

    sar_fe_datapath #(
        .DATA_W     (DATA_W),
        .LEAD_ZEROS (LEAD_ZEROS),
        .LOAD_EDGE  (LOAD_EDGE),
        .CTRL_W     (CTRL_W),
        .ADDR_W     (ADDR_W),
        .ADDR_LSB   (ADDR_LSB),
        .CONV_CLKS  (CONV_CLKS),
        .CNT_W      (CNT_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .din_s      (din_s),
        .fall_ev    (fall_ev),
        .fall_idx   (fall_idx),
        .rise_ev    (rise_ev),
        .rise_idx   (rise_idx),
        .conv_data  (conv_data),
        .dout_o     (dout),
        .chan_o     (chan_sel)
    );

    assign dout_oe = active;
    assign track   = (phase == PH_TRACK);
    assign pwr_dn  = (phase == PH_OFF) || (phase == PH_GAP);

endmodule

// File: rtl/sar_serial_fe_chk.sv
module sar_serial_fe_chk #(
    parameter int CNT_W     = 5,
    parameter int CONV_CLKS = 16,
    parameter int ADDR_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dout,
    input logic              dout_oe,
    input logic              track,
    input logic              pwr_dn,
    input logic [ADDR_W-1:0] chan_sel,
    input logic              fall_ev,
    input logic [CNT_W-1:0]  fall_idx
);

    // R1
    oe_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (!dout && !track && pwr_dn));

    // R2
    chan_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |=> $stable(chan_sel));

    // R3
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        track |-> !dout);

    // R10
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(track && pwr_dn));

    // R6
    chan_commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_sel) |-> pwr_dn);

    // R9
    fall_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ev |-> (fall_idx != '0 && fall_idx <= CNT_W'(CONV_CLKS)));

endmodule

bind sar_serial_fe sar_serial_fe_chk #(
    .CNT_W     (CNT_W),
    .CONV_CLKS (CONV_CLKS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .track    (track),
    .pwr_dn   (pwr_dn),
    .chan_sel (chan_sel),
    .fall_ev  (fall_ev),
    .fall_idx (fall_idx)
);

// File: tb/sar_serial_fe_tb.sv
module sar_serial_fe_tb;

    localparam int HP = 6;  // system clocks per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] conv_data;
    logic        dout;
    logic        dout_oe;
    logic [2:0]  chan_sel;
    logic        track;
    logic        pwr_dn;

    logic [11:0] vals [8];
    logic [2:0]  model_chan = 3'd0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign conv_data = vals[chan_sel];

    sar_serial_fe u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .conv_data (conv_data),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .chan_sel  (chan_sel),
        .track     (track),
        .pwr_dn    (pwr_dn)
    );

    function automatic logic [15:0] exp_word(input logic [11:0] v);
        return {4'b0000, v};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One conversion of nrise serial clocks; full ones check the word.
    task automatic run_conv(input bit skip_fall, input bit cont, input logic [7:0] ctl,
                            input int nrise, input logic [11:0] exp_res);
        logic [15:0] word = '0;
        for (int k = 0; k < nrise; k++) begin
            if (!(k == 0 && skip_fall)) sclk = 1'b0;
            din = (k < 8) ? ctl[7-k] : 1'($urandom_range(1));
            wait_clk(HP);
            word[15-k] = dout;
            if (k == 0) begin
                if (skip_fall)  chk("R8 track at select fall with clock low", 32'(track), 1);
                else if (cont)  chk("R9 track restarts back to back", 32'(track), 1);
                else            chk("R7 track after falling edge 1", 32'(track), 1);
                chk("R10 no power-down after falling edge 1", 32'(pwr_dn), 0);
            end
            if (k == 2) chk("R7 track after falling edge 3", 32'(track), 1);
            if (k == 3) chk("R7 convert after falling edge 4", 32'(track), 0);
            if (k == 14) chk("R10 awake after falling edge 15", 32'(pwr_dn), 0);
            if (k == 15) chk("R10 power-down after falling edge 16", 32'(pwr_dn), 1);
            sclk = 1'b1;
            wait_clk(HP);
        end
        if (nrise == 16) begin
            if (cont) chk("R9 R3 R4 back-to-back word", 32'(word), 32'(exp_word(exp_res)));
            else      chk("R3 R4 serial word", 32'(word), 32'(exp_word(exp_res)));
        end
    endtask

    task automatic frame(input bit low_start, input int nconv, input bit directed,
                         input logic [7:0] dctl);
        logic [7:0] ctl;
        sclk = low_start ? 1'b0 : 1'b1;
        wait_clk(HP);
        cs_n = 1'b0;
        if (!low_start) begin
            wait_clk(HP);
            chk("R8 no track before first clock fall", 32'(track), 0);
            chk("R8 no power-down before first clock fall", 32'(pwr_dn), 0);
            chk("R1 output enabled while selected", 32'(dout_oe), 1);
        end
        for (int c = 0; c < nconv; c++) begin
            ctl = directed ? dctl : 8'($urandom);
            run_conv(c == 0 && low_start, c > 0, ctl, 16, vals[model_chan]);
            model_chan = ctl[5:3];
        end
        cs_n = 1'b1;
        wait_clk(HP);
        chk("R6 channel from last control word", 32'(chan_sel), 32'(model_chan));
        chk("R1 output disabled after deselect", 32'(dout_oe), 0);
        chk("R10 power-down while deselected", 32'(pwr_dn), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int i = 0; i < 8; i++) vals[i] = 12'(i * 12'h111 + 12'h0A5);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // Reset state
        chk("R6 reset channel", 32'(chan_sel), 0);
        chk("R1 reset output disabled", 32'(dout_oe), 0);
        chk("R10 reset power-down", 32'(pwr_dn), 1);
        chk("R7 reset track low", 32'(track), 0);

        // Address pipelining and ignored control bits (R5)
        vals[0] = 12'hFFF;
        vals[7] = 12'h000;
        frame(1'b1, 1, 1'b1, 8'b0011_1000);   // address 7, others 0
        frame(1'b0, 1, 1'b1, 8'b1100_0111);   // address 0, others set
        chk("R5 ignored bits left channel 0", 32'(chan_sel), 0);
        frame(1'b1, 1, 1'b1, 8'b1101_0111);   // address 2
        chk("R5 address from bits 5:3", 32'(chan_sel), 2);

        // Continuous conversions
        frame(1'b0, 4, 1'b0, 8'h00);

        // Clock and data activity while deselected (R2)
        for (int k = 0; k < 40; k++) begin
            din = 1'($urandom_range(1));
            sclk = ~sclk;
            wait_clk(HP);
        end
        chk("R2 deselected clocks left channel", 32'(chan_sel), 32'(model_chan));
        chk("R2 deselected output disabled", 32'(dout_oe), 0);
        frame(1'b1, 1, 1'b0, 8'h00);

        // Aborted conversions (R11)
        for (int a = 0; a < 3; a++) begin
            sclk = 1'b0;
            wait_clk(HP);
            cs_n = 1'b0;
            run_conv(1'b1, 1'b0, {2'b00, 3'(~model_chan), 3'b000}, 6 + a * 4, 12'h000);
            cs_n = 1'b1;
            wait_clk(HP);
            chk("R11 abort keeps channel", 32'(chan_sel), 32'(model_chan));
            frame(a[0], 1, 1'b0, 8'h00);
        end

        // Random mix
        for (int f = 0; f < 25; f++) begin
            for (int i = 0; i < 8; i++) vals[i] = 12'($urandom);
            frame(1'($urandom_range(1)), 1 + int'($urandom_range(2)), 1'b0, 8'h00);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule